// File: doc/BRIEF.md
# DRAM Dynamic Power-Down Controller

This block controls the clock-enable lines of a DRAM array organised as row pairs, with one CKE output per pair. A single enable input turns the feature on. When it is on and every bank of a pair has been closed, with no access aimed at that pair, for a set number of cycles, the block drops CKE for that pair. Each pair is judged on its own, so one busy pair does not keep the others awake.

An access request carries the index of the pair it targets. If that pair is powered down, the block raises its CKE once the minimum low time has passed. It then holds the pair's ready output low for a fixed exit latency, after which the access may go ahead. The requester holds its request until the target pair's ready output is high. Clearing the enable input wakes every powered-down pair, again subject to the minimum low time.

Top module: `dram_pd_ctrl`

## Requirements
- R1: During and just after reset, every `cke` bit and every `pair_ready` bit is 1.
- R2: A `cke` bit can fall only if `pd_en` was 1 in the cycle before the edge that lowers it. With `pd_en` held at 0 from reset, no `cke` bit ever falls.
- R3: The `cke` bit of pair p falls only after IDLE_MIN consecutive cycles in which `pd_en` is 1, all BANKS_PER_PAIR bits of `bank_open[p*BANKS_PER_PAIR +: BANKS_PER_PAIR]` are 0, and no request targets p. If those conditions hold, the bit falls at the edge that ends the IDLE_MIN-th such cycle.
- R4: Once a `cke` bit falls, it stays 0 for at least LOW_MIN cycles, even when a request for that pair is present.
- R5: A request (`req_valid`=1, `req_pair`=p) held on a powered-down pair p raises `cke[p]` at the first edge at which the bit has been low for LOW_MIN cycles.
- R6: After `cke[p]` rises, `pair_ready[p]` stays 0 for exactly EXIT_LAT cycles and then goes to 1.
- R7: `pair_ready[p]` is 1 only when `cke[p]` is 1.
- R8: Power-down entry and exit are decided per pair. An open bank in one pair does not keep another pair awake, and waking one pair leaves the other pairs' `cke` unchanged.
- R9: Clearing `pd_en` while a pair is powered down raises that pair's `cke` without any request, at the first edge at which the bit has been low for LOW_MIN cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_en | input | 1 | Enables dynamic power-down |
| bank_open | input | NUM_PAIRS*BANKS_PER_PAIR | Open flag for each bank. Pair p owns bits p*BANKS_PER_PAIR and up |
| req_valid | input | 1 | An access request is present |
| req_pair | input | PW | Index of the pair the request targets |
| cke | output | NUM_PAIRS | Clock enable for each row pair |
| pair_ready | output | NUM_PAIRS | The pair is awake and may be accessed |

## Verification
The bench goes after the exact cycle at which CKE drops once the idle window completes. A design with an off-by-one count would drop one cycle early or late, or toggle on back-to-back accesses. It sends a request on the very cycle after a drop, which catches a design that cuts the minimum low time short. It also counts the exit latency, where a wrong design raises ready together with CKE. It clears the enable while pairs are down, where a faulty design leaves them asleep until a request arrives. It also mixes busy and idle pairs, where a design that shares state between pairs would wake or hold the wrong pair.

// File: rtl/dpd_pkg.sv
package dpd_pkg;
  typedef enum logic [1:0] {
    PD_AWAKE = 2'd0,
    PD_ASLEEP = 2'd1,
    PD_WAKING = 2'd2
  } pd_state_e;
endpackage

// File: rtl/dpd_pair_decode.sv
module dpd_pair_decode #(
  parameter int NUM_PAIRS      = 4,
  parameter int BANKS_PER_PAIR = 4,
  parameter int PW             = 2
) (
  input  logic [NUM_PAIRS*BANKS_PER_PAIR-1:0] bank_open,
  input  logic                                req_valid,
  input  logic [PW-1:0]                       req_pair,
  output logic [NUM_PAIRS-1:0]                req_hit,
  output logic [NUM_PAIRS-1:0]                all_closed
);
  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    assign req_hit[p]    = req_valid && (req_pair == PW'(p));
    assign all_closed[p] = ~|bank_open[p*BANKS_PER_PAIR +: BANKS_PER_PAIR];
  end
endmodule

// File: rtl/dpd_pair_fsm.sv
module dpd_pair_fsm
  import dpd_pkg::*;
#(
  parameter int IDLE_MIN = 6,
  parameter int LOW_MIN  = 4,
  parameter int EXIT_LAT = 3,
  localparam int CMAX    = (IDLE_MIN > LOW_MIN) ?
                           ((IDLE_MIN > EXIT_LAT) ? IDLE_MIN : EXIT_LAT) :
                           ((LOW_MIN > EXIT_LAT) ? LOW_MIN : EXIT_LAT),
  localparam int CW      = $clog2(CMAX + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic req_hit,
  input  logic all_closed,
  output logic cke,
  output logic ready
);
  pd_state_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic idle_ok, wake;

  assign idle_ok = en && all_closed && !req_hit;
  assign wake    = req_hit || !en;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      PD_AWAKE: begin
        if (!idle_ok) begin
          cnt_d = '0;
        end else if (cnt_q == CW'(IDLE_MIN - 1)) begin
          st_d  = PD_ASLEEP;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PD_ASLEEP: begin
        if (cnt_q != CW'(LOW_MIN - 1)) begin
          cnt_d = cnt_q + 1'b1;
        end else if (wake) begin
          st_d  = PD_WAKING;
          cnt_d = '0;
        end
      end
      PD_WAKING: begin
        if (cnt_q == CW'(EXIT_LAT - 1)) begin
          st_d  = PD_AWAKE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        st_d  = PD_AWAKE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PD_AWAKE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign cke   = (st_q != PD_ASLEEP);
  assign ready = (st_q == PD_AWAKE);
endmodule

// File: rtl/dram_pd_ctrl.sv
module dram_pd_ctrl #(
  parameter int NUM_PAIRS      = 4,
  parameter int BANKS_PER_PAIR = 4,
  parameter int IDLE_MIN       = 6,
  parameter int LOW_MIN        = 4,
  parameter int EXIT_LAT       = 3,
  localparam int PW            = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                pd_en,
  input  logic [NUM_PAIRS*BANKS_PER_PAIR-1:0] bank_open,
  input  logic                                req_valid,
  input  logic [PW-1:0]                       req_pair,
  output logic [NUM_PAIRS-1:0]                cke,
  output logic [NUM_PAIRS-1:0]                pair_ready
);
  logic [NUM_PAIRS-1:0] req_hit;
  logic [NUM_PAIRS-1:0] all_closed;

  dpd_pair_decode #(
    .NUM_PAIRS(NUM_PAIRS), .BANKS_PER_PAIR(BANKS_PER_PAIR), .PW(PW)
  ) i_decode (
    .bank_open(bank_open), .req_valid(req_valid), .req_pair(req_pair),
    .req_hit(req_hit), .all_closed(all_closed)
  );

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    dpd_pair_fsm #(
      .IDLE_MIN(IDLE_MIN), .LOW_MIN(LOW_MIN), .EXIT_LAT(EXIT_LAT)
    ) i_fsm (
      .clk(clk), .rst_n(rst_n), .en(pd_en),
      .req_hit(req_hit[p]), .all_closed(all_closed[p]),
      .cke(cke[p]), .ready(pair_ready[p])
    );
  end
endmodule

// File: rtl/dram_pd_ctrl_chk.sv
module dram_pd_ctrl_chk #(
  parameter int NUM_PAIRS      = 4,
  parameter int BANKS_PER_PAIR = 4,
  parameter int IDLE_MIN       = 6,
  parameter int LOW_MIN        = 4,
  parameter int EXIT_LAT       = 3,
  parameter int PW             = 2
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic                                pd_en,
  input logic [NUM_PAIRS*BANKS_PER_PAIR-1:0] bank_open,
  input logic                                req_valid,
  input logic [PW-1:0]                       req_pair,
  input logic [NUM_PAIRS-1:0]                cke,
  input logic [NUM_PAIRS-1:0]                pair_ready
);
  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_chk
    logic [15:0] idle_run, low_len, hi_len;
    logic        hit, quiet;
    assign hit   = req_valid && (req_pair == PW'(p));
    assign quiet = pd_en && !hit &&
                   (bank_open[p*BANKS_PER_PAIR +: BANKS_PER_PAIR] == '0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        idle_run <= '0;
        low_len  <= '0;
        hi_len   <= '0;
      end else begin
        idle_run <= !quiet ? '0 : (idle_run < 16'(IDLE_MIN)) ? idle_run + 1'b1 : idle_run;
        low_len  <= cke[p] ? '0 : (low_len < 16'(LOW_MIN)) ? low_len + 1'b1 : low_len;
        hi_len   <= !cke[p] ? '0 : (hi_len < 16'(EXIT_LAT)) ? hi_len + 1'b1 : hi_len;
      end
    end

    a_r2_fall_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cke[p]) |-> $past(pd_en));
    a_r3_idle_before_drop: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cke[p]) |-> idle_run >= 16'(IDLE_MIN));
    a_r4_min_low_time: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cke[p]) |-> low_len >= 16'(LOW_MIN));
    a_r5_request_wakes: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !cke[p] && low_len >= 16'(LOW_MIN - 1)) |=> cke[p]);
    a_r6_exit_latency: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pair_ready[p]) |-> hi_len == 16'(EXIT_LAT));
    a_r7_ready_needs_cke: assert property (@(posedge clk) disable iff (!rst_n)
      pair_ready[p] |-> cke[p]);
    a_r9_disable_wakes: assert property (@(posedge clk) disable iff (!rst_n)
      (!pd_en && !cke[p] && low_len >= 16'(LOW_MIN - 1)) |=> cke[p]);
  end
endmodule

bind dram_pd_ctrl dram_pd_ctrl_chk #(
  .NUM_PAIRS(NUM_PAIRS), .BANKS_PER_PAIR(BANKS_PER_PAIR), .IDLE_MIN(IDLE_MIN),
  .LOW_MIN(LOW_MIN), .EXIT_LAT(EXIT_LAT), .PW(PW)
) i_chk (
  .clk(clk), .rst_n(rst_n), .pd_en(pd_en), .bank_open(bank_open),
  .req_valid(req_valid), .req_pair(req_pair), .cke(cke), .pair_ready(pair_ready)
);

// File: tb/test_dram_pd_ctrl.sv
module test_dram_pd_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NP  = 4;
  localparam int NB  = 4;
  localparam int IDL = 6;
  localparam int LOW = 4;
  localparam int EXL = 3;
  localparam int PW  = 2;

  logic            clk, rst_n, pd_en, req_valid;
  logic [NP*NB-1:0] bank_open;
  logic [PW-1:0]   req_pair;
  logic [NP-1:0]   cke, pair_ready;

  int tests, fails;
  int mst [NP];
  int mcnt[NP];

  dram_pd_ctrl #(.NUM_PAIRS(NP), .BANKS_PER_PAIR(NB), .IDLE_MIN(IDL),
                 .LOW_MIN(LOW), .EXIT_LAT(EXL)) i_dram_pd_ctrl (
    .clk(clk), .rst_n(rst_n), .pd_en(pd_en), .bank_open(bank_open),
    .req_valid(req_valid), .req_pair(req_pair), .cke(cke), .pair_ready(pair_ready));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Expected behaviour per pair: 0 awake, 1 asleep, 2 waking
  function automatic bit exp_cke(int s);   return s != 1; endfunction
  function automatic bit exp_ready(int s); return s == 0; endfunction

  always @(posedge clk or negedge rst_n) begin
    for (int p = 0; p < NP; p++) begin
      if (!rst_n) begin
        mst[p] <= 0; mcnt[p] <= 0;
      end else begin
        bit hit, quiet;
        hit   = req_valid && (int'(req_pair) == p);
        quiet = pd_en && !hit && (bank_open[p*NB +: NB] == '0);
        if (mst[p] == 0) begin
          if (!quiet) mcnt[p] <= 0;
          else if (mcnt[p] + 1 >= IDL) begin mst[p] <= 1; mcnt[p] <= 0; end
          else mcnt[p] <= mcnt[p] + 1;
        end else if (mst[p] == 1) begin
          if (mcnt[p] + 1 < LOW) mcnt[p] <= mcnt[p] + 1;
          else if (hit || !pd_en) begin mst[p] <= 2; mcnt[p] <= 0; end
        end else begin
          if (mcnt[p] + 1 >= EXL) begin mst[p] <= 0; mcnt[p] <= 0; end
          else mcnt[p] <= mcnt[p] + 1;
        end
      end
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      check(cke[p] == exp_cke(mst[p]), "R3 R4 R5 R9 model cke", cke[p], exp_cke(mst[p]));
      check(pair_ready[p] == exp_ready(mst[p]), "R6 R7 model ready",
            pair_ready[p], exp_ready(mst[p]));
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    int seed;
    tests = 0; fails = 0;
    seed = 7;
    void'($urandom(seed));
    rst_n = 1'b0; pd_en = 1'b0; req_valid = 1'b0; req_pair = '0; bank_open = '0;
    @(negedge clk); @(negedge clk);
    check(cke == '1, "R1 reset cke", cke, 4'hf);
    check(pair_ready == '1, "R1 reset ready", pair_ready, 4'hf);
    rst_n = 1'b1;
    step();
    check(cke == '1 && pair_ready == '1, "R1 after reset", {cke, pair_ready}, 8'hff);

    // R2: disabled, all banks closed, no drop
    for (int i = 0; i < 20; i++) step();
    check(cke == '1, "R2 disabled keeps cke", cke, 4'hf);

    // R3 / R8: enable; pair 1 keeps a bank open
    bank_open = '0;
    bank_open[1*NB + 2] = 1'b1;
    pd_en = 1'b1;
    for (int i = 0; i < IDL - 1; i++) step();
    check(cke[0] == 1'b1, "R3 no early drop", cke[0], 1);
    step();
    check(cke[0] == 1'b0, "R3 drop on time", cke[0], 0);
    check(cke[1] == 1'b1, "R8 busy pair stays up", cke[1], 1);

    // R4 / R5: request to pair 0 right after the drop
    req_valid = 1'b1; req_pair = 2'd0;
    for (int i = 0; i < LOW - 1; i++) step();
    check(cke[0] == 1'b0, "R4 min low time held", cke[0], 0);
    step();
    check(cke[0] == 1'b1, "R5 request wakes pair", cke[0], 1);
    check(pair_ready[0] == 1'b0, "R6 not ready at wake", pair_ready[0], 0);
    check(cke[2] == 1'b0 && cke[3] == 1'b0, "R8 other pairs stay down", cke[3:2], 0);
    for (int i = 0; i < EXL - 1; i++) step();
    check(pair_ready[0] == 1'b0, "R6 exit latency held", pair_ready[0], 0);
    step();
    check(pair_ready[0] == 1'b1, "R6 ready after latency", pair_ready[0], 1);
    req_valid = 1'b0;

    // R9: clear enable while pairs 2 and 3 are down
    pd_en = 1'b0;
    step();
    check(cke[3:2] == 2'b11, "R9 disable wakes pairs", cke[3:2], 3);
    for (int i = 0; i < EXL; i++) step();
    check(pair_ready == '1, "R6 R9 all ready", pair_ready, 4'hf);

    // Constrained random traffic
    pd_en = 1'b1;
    bank_open = '0;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 300 == 0) pd_en = ~pd_en;
      for (int p = 0; p < NP; p++)
        if ($urandom % 8 == 0)
          bank_open[p*NB +: NB] = ($urandom % 3 == 0) ? NB'($urandom) : '0;
      req_valid = ($urandom % 12 == 0);
      req_pair  = PW'($urandom);
      step();
    end
    finish_run();
  end
endmodule